// File: doc/BRIEF.md
# Trigger-Centered Capture Window Controller

This controller steers writes into an external circular sample memory so that, when capture ends, the memory holds a window of `DEPTH` samples with the trigger sample at its middle. Half of the window holds samples taken before the trigger and half holds samples taken after it. An arm pulse starts a run. Each sample strobe writes one word at the next ring address. The first strobe that carries the trigger marks the trigger address. The post-trigger half then fills, and writing stops on its own.

The run can also end when the surrounding capture engine signals the end of its main capture. At that point the controller decides whether a usable window exists. If not, it records why: too few samples stored, no trigger seen, a trigger that came before the pre-trigger half could fill, or a trigger too close to the end for the post-trigger half to fill. A readout stage uses the window start address and the trigger address to unroll the ring. The oversampling multiplier that applies to the window (4 in normal timing, 8 in transitional timing) is latched at arm and reported beside the status.

`DEPTH` must be a power of two and at least 4. `HALF` is `DEPTH/2`.

Top module: `cwin_ctrl_top`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `window_valid_o` and `mem_we_o` are 0 and `status_o` is 0 (pending). A pulse on `arm_i` starts a run: it clears all counts, sets the next write address to 0 and sets `busy_o`.
- R2: While busy, each `sample_valid_i` asserts `mem_we_o` in the same cycle. It drives `mem_addr_o` with the current ring address, starting at 0 and incrementing modulo `DEPTH`, and drives `mem_wdata_o` with `sample_data_i`. No write occurs while idle or done.
- R3: A trigger counts only when `trigger_i` and `sample_valid_i` are high together during the pre-trigger phase. That sample's address becomes `trig_addr_o`. A trigger without a strobe, or any later trigger in the run, is ignored.
- R4: The trigger sample is the first of the post-trigger half. Once `HALF` samples counting the trigger sample have been written, `done_o` rises and further strobes write nothing.
- R5: `win_start_o` equals `(trig_addr_o - HALF) mod DEPTH`.
- R6: `status_o` encodes the outcome: 0 pending, 1 valid, 2 too few samples, 3 no trigger, 4 trigger too early, 5 trigger too late. It stays 0 until done. `window_valid_o` is 1 exactly when done with status 1.
- R7: If `main_end_i` arrives while busy and fewer than `HALF` samples have been stored in the run, the status is 2. This takes priority over every other failure.
- R8: If `main_end_i` arrives before any trigger and at least `HALF` samples are stored, the status is 3.
- R9: A trigger accepted with fewer than `HALF` samples already stored makes the outcome 4, whether the post half completes or the capture ends first with at least `HALF` samples.
- R10: If `main_end_i` arrives after a trigger with a full pre-trigger half but before the post half is complete, the status is 5.
- R11: Once done, `main_end_i`, `trigger_i` and strobes change neither the status nor the addresses until the next arm. Completing the post half in the same cycle as `main_end_i` counts as completion.
- R12: `rate_mult_o` reports 4 when `mode_i` was 0 at arm and 8 when it was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Start a new run |
| mode_i | input | 1 | 0 normal timing, 1 transitional timing; latched at arm |
| sample_valid_i | input | 1 | Sample strobe |
| sample_data_i | input | DATA_W | Sample word |
| trigger_i | input | 1 | Trigger event, qualified by the strobe |
| main_end_i | input | 1 | Main capture has ended |
| mem_we_o | output | 1 | Ring memory write enable |
| mem_addr_o | output | AW | Ring memory write address |
| mem_wdata_o | output | DATA_W | Ring memory write data |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished |
| window_valid_o | output | 1 | Finished with a usable window |
| status_o | output | 3 | Outcome code |
| trig_addr_o | output | AW | Ring address of the trigger sample |
| win_start_o | output | AW | Ring address of the oldest window sample |
| rate_mult_o | output | MW | Window oversampling multiplier |

## Verification
The main function is swept over every pairing of trigger position and capture-end position on a 16-deep ring. Trigger positions run from the first sample to well past a full ring, and the end comes before, at, around and long after the point where the post half fills. This sweep separates all five outcomes and shows where each boundary lies: exactly `HALF` samples before the trigger, and exactly `HALF` samples after it. Each run also carries a strobe-less trigger before the first sample and a second trigger two samples after the real one. These show that only strobed, first triggers move the trigger address. Runs alternate the mode bit and are re-armed without reset, which confirms that arm clears the previous run and latches the multiplier.

// File: rtl/cwin_pkg.sv
package cwin_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRE  = 2'd1,
    PH_POST = 2'd2,
    PH_DONE = 2'd3
  } phase_e;

  typedef enum logic [2:0] {
    ST_PENDING = 3'd0,
    ST_VALID   = 3'd1,
    ST_SHORT   = 3'd2,
    ST_NOTRIG  = 3'd3,
    ST_EARLY   = 3'd4,
    ST_LATE    = 3'd5
  } status_e;
endpackage

// File: rtl/cwin_ring_ptr.sv
module cwin_ring_ptr #(
  parameter int DEPTH = 16384,
  localparam int AW   = $clog2(DEPTH),
  localparam int HALF = DEPTH / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          wr_i,
  output logic [AW-1:0] ptr_o,
  output logic          full_o,
  output logic          full_nxt_o
);
  logic [AW-1:0] ptr_q;
  logic [AW-1:0] cnt_q;

  // cnt_q saturates at HALF; it only needs to answer "half filled yet"
  assign full_o     = (cnt_q == AW'(HALF));
  assign full_nxt_o = full_o | (wr_i & (cnt_q == AW'(HALF - 1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else if (wr_i) begin
      ptr_q <= ptr_q + AW'(1);
      if (!full_o) cnt_q <= cnt_q + AW'(1);
    end
  end

  assign ptr_o = ptr_q;

  a_r2_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !clear_i) |=> ptr_o == $past(ptr_o) + AW'(1));
  a_r2_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !clear_i) |=> $stable(ptr_o));
  a_r7_cnt_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= AW'(HALF));
endmodule

// File: rtl/cwin_rate.sv
module cwin_rate #(
  parameter int NORM_MULT  = 4,
  parameter int TRANS_MULT = 8,
  localparam int MW = $clog2(((NORM_MULT > TRANS_MULT) ? NORM_MULT : TRANS_MULT) + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic          mode_i,
  output logic [MW-1:0] mult_o
);
  logic mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mode_q <= 1'b0;
    else if (arm_i) mode_q <= mode_i;
  end

  generate
    if (NORM_MULT == TRANS_MULT) begin : g_fixed
      assign mult_o = MW'(NORM_MULT);
    end else begin : g_sel
      assign mult_o = mode_q ? MW'(TRANS_MULT) : MW'(NORM_MULT);
    end
  endgenerate

  a_r12_mode_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> $stable(mult_o));
endmodule

// File: rtl/cwin_ctrl.sv
module cwin_ctrl
  import cwin_pkg::*;
#(
  parameter int DEPTH = 16384,
  localparam int AW   = $clog2(DEPTH),
  localparam int HALF = DEPTH / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic          strobe_i,
  input  logic          trig_i,
  input  logic          end_i,
  input  logic [AW-1:0] ptr_i,
  input  logic          full_i,
  input  logic          full_nxt_i,
  output logic          wr_o,
  output phase_e        phase_o,
  output status_e       status_o,
  output logic [AW-1:0] trig_addr_o
);
  phase_e        phase_q, phase_n;
  status_e       status_q, status_n;
  logic [AW-1:0] trig_q, trig_n;
  logic [AW-1:0] post_q, post_n;
  logic          early_q, early_n;
  logic          trig_hit, post_fill;

  assign wr_o      = strobe_i & !arm_i & ((phase_q == PH_PRE) | (phase_q == PH_POST));
  assign trig_hit  = wr_o & trig_i & (phase_q == PH_PRE);
  assign post_fill = wr_o & (phase_q == PH_POST) & (post_q == AW'(HALF - 1));

  always_comb begin
    phase_n  = phase_q;
    status_n = status_q;
    trig_n   = trig_q;
    post_n   = post_q;
    early_n  = early_q;
    if (arm_i) begin
      phase_n  = PH_PRE;
      status_n = ST_PENDING;
      trig_n   = '0;
      post_n   = '0;
      early_n  = 1'b0;
    end else begin
      unique case (phase_q)
        PH_PRE: begin
          if (trig_hit) begin
            trig_n  = ptr_i;
            early_n = !full_i;    // pre half not filled before trigger sample
            post_n  = AW'(1);
            phase_n = PH_POST;
          end
          if (end_i) begin
            phase_n = PH_DONE;
            if (!full_nxt_i)   status_n = ST_SHORT;
            else if (!trig_hit) status_n = ST_NOTRIG;
            else if (early_n)  status_n = ST_EARLY;
            else               status_n = ST_LATE;
          end
        end
        PH_POST: begin
          if (wr_o) post_n = post_q + AW'(1);
          if (post_fill) begin
            phase_n  = PH_DONE;
            status_n = early_q ? ST_EARLY : ST_VALID;
          end else if (end_i) begin
            phase_n = PH_DONE;
            if (!full_nxt_i)  status_n = ST_SHORT;
            else if (early_q) status_n = ST_EARLY;
            else              status_n = ST_LATE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      status_q <= ST_PENDING;
      trig_q   <= '0;
      post_q   <= '0;
      early_q  <= 1'b0;
    end else begin
      phase_q  <= phase_n;
      status_q <= status_n;
      trig_q   <= trig_n;
      post_q   <= post_n;
      early_q  <= early_n;
    end
  end

  assign phase_o     = phase_q;
  assign status_o    = status_q;
  assign trig_addr_o = trig_q;

  a_r6_pending_until_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_DONE) |-> (status_q == ST_PENDING));
  a_r9_valid_not_early: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q == ST_VALID) |-> !early_q);
  a_r3_trig_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_POST && !arm_i) |=> $stable(trig_addr_o));
  a_r11_done_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_DONE && !arm_i) |=> (phase_q == PH_DONE) && $stable(status_q) && $stable(trig_addr_o));
  a_r4_post_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_POST) |-> (post_q != '0) && (post_q <= AW'(HALF - 1)));
endmodule

// File: rtl/cwin_ctrl_top.sv
module cwin_ctrl_top
  import cwin_pkg::*;
#(
  parameter int DEPTH      = 16384,
  parameter int DATA_W     = 36,
  parameter int NORM_MULT  = 4,
  parameter int TRANS_MULT = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int HALF = DEPTH / 2,
  localparam int MW   = $clog2(((NORM_MULT > TRANS_MULT) ? NORM_MULT : TRANS_MULT) + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              mode_i,
  input  logic              sample_valid_i,
  input  logic [DATA_W-1:0] sample_data_i,
  input  logic              trigger_i,
  input  logic              main_end_i,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              window_valid_o,
  output logic [2:0]        status_o,
  output logic [AW-1:0]     trig_addr_o,
  output logic [AW-1:0]     win_start_o,
  output logic [MW-1:0]     rate_mult_o
);
  logic          wr;
  logic [AW-1:0] ptr;
  logic          full, full_nxt;
  phase_e        phase;
  status_e       status;
  logic [AW-1:0] trig_addr;

  cwin_ring_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (arm_i),
    .wr_i       (wr),
    .ptr_o      (ptr),
    .full_o     (full),
    .full_nxt_o (full_nxt)
  );

  cwin_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .arm_i       (arm_i),
    .strobe_i    (sample_valid_i),
    .trig_i      (trigger_i),
    .end_i       (main_end_i),
    .ptr_i       (ptr),
    .full_i      (full),
    .full_nxt_i  (full_nxt),
    .wr_o        (wr),
    .phase_o     (phase),
    .status_o    (status),
    .trig_addr_o (trig_addr)
  );

  cwin_rate #(.NORM_MULT(NORM_MULT), .TRANS_MULT(TRANS_MULT)) u_rate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (arm_i),
    .mode_i (mode_i),
    .mult_o (rate_mult_o)
  );

  assign mem_we_o       = wr;
  assign mem_addr_o     = ptr;
  assign mem_wdata_o    = sample_data_i;
  assign busy_o         = (phase == PH_PRE) || (phase == PH_POST);
  assign done_o         = (phase == PH_DONE);
  assign status_o       = status;
  assign window_valid_o = done_o && (status == ST_VALID);
  assign trig_addr_o    = trig_addr;
  // power-of-two depth: the subtraction wraps modulo DEPTH
  assign win_start_o    = trig_addr - AW'(HALF);

  a_r2_no_write_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_we_o);
  a_r1_arm_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> busy_o && (mem_addr_o == '0) && (status_o == 3'd0));
  a_r6_valid_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    window_valid_o |-> done_o && !busy_o);
endmodule

// File: tb/cwin_ctrl_top_tb_top.sv
module cwin_ctrl_top_tb_top;
  localparam int DEPTH  = 16;
  localparam int HALF   = DEPTH / 2;
  localparam int DATA_W = 12;
  localparam int AW     = 4;
  localparam int MW     = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              arm = 1'b0, mode = 1'b0, sv = 1'b0, trig = 1'b0, mend = 1'b0;
  logic [DATA_W-1:0] sdata = '0;
  logic              we, busy, done, wvalid;
  logic [AW-1:0]     waddr, taddr, wstart;
  logic [DATA_W-1:0] wdata;
  logic [2:0]        status;
  logic [MW-1:0]     mult;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  cwin_ctrl_top #(.DEPTH(DEPTH), .DATA_W(DATA_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .mode_i(mode),
    .sample_valid_i(sv), .sample_data_i(sdata), .trigger_i(trig), .main_end_i(mend),
    .mem_we_o(we), .mem_addr_o(waddr), .mem_wdata_o(wdata),
    .busy_o(busy), .done_o(done), .window_valid_o(wvalid), .status_o(status),
    .trig_addr_o(taddr), .win_start_o(wstart), .rate_mult_o(mult)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(input int k, input int e, input bit m);
    int writes = 0;
    int bad = 0;
    int exp_wr, exp_st;
    @(negedge clk); arm = 1'b1; mode = m;
    @(negedge clk); arm = 1'b0;
    trig = 1'b1; sv = 1'b0;                       // R3 strobe-less trigger
    @(negedge clk); trig = 1'b0;
    for (int i = 0; i < e; i++) begin
      @(negedge clk);
      sv = 1'b1; sdata = DATA_W'(i * 7 + k);
      trig = (i == k) || (i == k + 2);            // R3 second trigger ignored
      #1;
      if (we) begin
        if (waddr != AW'(writes) || wdata != DATA_W'(i * 7 + k)) bad++;
        writes++;
      end
    end
    @(negedge clk); sv = 1'b0; trig = 1'b0; mend = 1'b1;
    @(negedge clk); mend = 1'b0;
    #1;
    if (k < e) exp_wr = (e < k + HALF) ? e : k + HALF;
    else       exp_wr = e;
    if (k < e && e >= k + HALF) exp_st = (k < HALF) ? 4 : 1;
    else if (exp_wr < HALF)     exp_st = 2;
    else if (k >= e)            exp_st = 3;
    else if (k < HALF)          exp_st = 4;
    else                        exp_st = 5;
    check("R2 write addresses/data", bad, 0);
    check("R4 write count", writes, exp_wr);
    check("R6 status (R7/R8/R9/R10/R11)", int'(status), exp_st);
    check("R4 done", int'(done), 1);
    check("R6 window_valid", int'(wvalid), int'(exp_st == 1));
    check("R12 rate_mult", int'(mult), m ? 8 : 4);
    if (k < e) begin
      check("R3 trig_addr", int'(taddr), k % DEPTH);
      check("R5 win_start", int'(wstart), (k + DEPTH - HALF) % DEPTH);
    end
    // R11: end again while done changes nothing
    @(negedge clk); mend = 1'b1; sv = 1'b1; trig = 1'b1;
    #1;
    check("R11 no write when done", int'(we), 0);
    @(negedge clk); mend = 1'b0; sv = 1'b0; trig = 1'b0;
    #1;
    check("R11 status held", int'(status), exp_st);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset busy", int'(busy), 0);
    check("R1 reset done", int'(done), 0);
    check("R1 reset status", int'(status), 0);
    check("R1 reset valid", int'(wvalid), 0);
    rst_n = 1'b1;
    @(negedge clk); sv = 1'b1; trig = 1'b1;
    #1;
    check("R2 no write while idle", int'(we), 0);
    @(negedge clk); sv = 1'b0; trig = 1'b0;
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
    #1;
    check("R1 busy after arm", int'(busy), 1);
    check("R1 address zero after arm", int'(waddr), 0);
    check("R6 pending while busy", int'(status), 0);
    for (int k = 0; k <= 26; k++)
      for (int e = 0; e <= 34; e++)
        run(k, e, bit'((k + e) % 2));
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule